// File: doc/BRIEF.md
# I2C Slave Address Recognition Unit

This block is the slave-side front end of an I2C port. It brings SCL and SDA into the system clock domain, finds START, repeated START and STOP conditions, and shifts in address bytes. It decides whether to acknowledge each byte, and it pulls SDA low during the acknowledge slot when it does. It recognises a 7-bit own address, or a 10-bit own address sent as a header byte plus a low-address byte, and it can also recognise the general call address.

For a 10-bit read, the master first writes the header and the low byte, then issues a repeated START and sends the header again with the read bit set. Only a slave that matched both earlier bytes takes this resent header. That matched state survives repeated STARTs. A STOP clears it, and so does any first byte or second byte that does not match. Three events feed a single sticky interrupt flag that is cleared by writing one: an acknowledged byte completing, an address match, and an arbitration-lost pulse from a neighbouring master. The interrupt output is that flag gated by an enable. The byte register lets software tell a general call (0x00) apart from an own-address match.

Top module: `i2c_addr_slave`

## Requirements
- R1: After reset, sda_oe, rx_data, sel_flag, slave_rd, xfer_done, arb_flag, irq_flag and irq are all 0.
- R2: In 7-bit mode (ten_bit_en=0), a first byte whose bits 7:1 equal own_addr[6:0] is acknowledged with sda_oe=1 while SCL is low before the 9th clock. After the 9th falling SCL edge, sel_flag=1, slave_rd equals the byte's bit 0, and rx_data holds the byte.
- R3: In 7-bit mode, a first byte that matches neither the own address nor an enabled general call is not acknowledged and leaves sel_flag and xfer_done at 0.
- R4: The byte 0x00 is a general call. With gc_en=1 it is acknowledged, sel_flag=1, slave_rd=0 and rx_data=0x00. With gc_en=0 it is not acknowledged.
- R5: In 10-bit mode, a first byte of 11110, own_addr[9:8], 0 is acknowledged and sets xfer_done, but sel_flag stays 0. Any other header value is not acknowledged.
- R6: In 10-bit mode, the byte after an accepted header is acknowledged and sets sel_flag only if it equals own_addr[7:0]. Otherwise it is not acknowledged and the 10-bit match is forgotten.
- R7: After a repeated START, a header 11110, own_addr[9:8], 1 is acknowledged only if both earlier address bytes matched. When it is acknowledged, sel_flag=1 and slave_rd=1. slave_rd is never 1 while sel_flag is 0.
- R8: A STOP clears the 10-bit matched state, so a header with the read bit set after a new START is not acknowledged.
- R9: After a write-address match, every data byte is acknowledged, is placed in rx_data, and sets xfer_done on the 9th falling SCL edge. A START clears xfer_done.
- R10: irq_flag is set by an xfer_done event, a match event or an arb_lost_i pulse, and is cleared by a flag_clr pulse. When a set and a clear fall in the same cycle, the set wins. arb_flag is set by arb_lost_i and cleared by flag_clr.
- R11: irq equals irq_flag AND irq_en.
- R12: With blk_en=0, no byte is acknowledged and no flag is set.
- R13: A STOP clears sel_flag and slave_rd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| blk_en | input | 1 | Block enable |
| ten_bit_en | input | 1 | 1 selects 10-bit addressing |
| gc_en | input | 1 | Accept the general call address |
| irq_en | input | 1 | Interrupt enable |
| own_addr | input | 10 | Own slave address (bits 6:0 are used in 7-bit mode) |
| flag_clr | input | 1 | Write-one-to-clear pulse for irq_flag and arb_flag |
| arb_lost_i | input | 1 | Arbitration-lost event pulse |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge) |
| rx_data | output | 8 | Last received byte |
| sel_flag | output | 1 | Addressed as slave |
| slave_rd | output | 1 | Addressed for a read |
| xfer_done | output | 1 | Acknowledged byte complete |
| arb_flag | output | 1 | Arbitration lost status |
| irq_flag | output | 1 | Sticky interrupt flag |
| irq | output | 1 | Masked interrupt |

## Verification
The interrupt flag's set path and its write-one-to-clear path can land in the same system clock cycle. The bench provokes this by driving arb_lost_i and flag_clr together on one edge. It judges the result by checking that irq_flag and arb_flag both read 1 afterwards, and that a lone flag_clr then drops them. Address recognition is swept over every first-byte value in 7-bit mode and over every 10-bit header value, with the expected acknowledge computed from the address arithmetic.

// File: rtl/i2c_sar_pkg.sv
package i2c_sar_pkg;
  localparam int BYTE_W   = 8;
  localparam int ADDR_W   = 10;
  localparam int BCNT_W   = 4;
  localparam int ACK_SLOT = 9;
  localparam logic [4:0] TEN_HDR = 5'b11110;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_FIRST,
    PH_SECOND,
    PH_DATA
  } phase_e;
endpackage

// File: rtl/sar_line_sync.sv
module sar_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic start_p,
  output logic stop_p,
  output logic scl_rise,
  output logic scl_fall
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_prv, sda_prv;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_sh <= '1;
          sda_sh <= '1;
        end else begin
          scl_sh <= scl_i;
          sda_sh <= sda_i;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_sh <= '1;
          sda_sh <= '1;
        end else begin
          scl_sh <= {scl_sh[STAGES-2:0], scl_i};
          sda_sh <= {sda_sh[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  assign scl_s = scl_sh[STAGES-1];
  assign sda_s = sda_sh[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_prv <= 1'b1;
      sda_prv <= 1'b1;
    end else begin
      scl_prv <= scl_s;
      sda_prv <= sda_s;
    end
  end

  assign start_p  = scl_s & scl_prv & sda_prv & ~sda_s;
  assign stop_p   = scl_s & scl_prv & ~sda_prv & sda_s;
  assign scl_rise = scl_s & ~scl_prv;
  assign scl_fall = ~scl_s & scl_prv;
endmodule

// File: rtl/sar_addr_decode.sv
module sar_addr_decode
  import i2c_sar_pkg::*;
(
  input  phase_e              phase,
  input  logic [BYTE_W-1:0]   rx_byte,
  input  logic [ADDR_W-1:0]   own_addr,
  input  logic                ten_bit_en,
  input  logic                gc_en,
  input  logic                tb_matched,
  output logic                ack,
  output logic                match,
  output logic                rd,
  output logic                tbm_set,
  output logic                tbm_clr,
  output phase_e              next_phase
);
  logic gc_hit, hdr_hit, low_hit, sev_hit;

  assign gc_hit  = gc_en && (rx_byte == '0);
  assign hdr_hit = (rx_byte[7:3] == TEN_HDR) && (rx_byte[2:1] == own_addr[9:8]);
  assign low_hit = (rx_byte == own_addr[7:0]);
  assign sev_hit = (rx_byte[7:1] == own_addr[6:0]);

  always_comb begin
    ack        = 1'b0;
    match      = 1'b0;
    rd         = 1'b0;
    tbm_set    = 1'b0;
    tbm_clr    = 1'b0;
    next_phase = PH_IDLE;
    unique case (phase)
      PH_FIRST: begin
        if (gc_hit) begin
          ack        = 1'b1;
          match      = 1'b1;
          tbm_clr    = 1'b1;
          next_phase = PH_DATA;
        end else if (ten_bit_en) begin
          if (hdr_hit && !rx_byte[0]) begin
            ack        = 1'b1;
            tbm_clr    = 1'b1;
            next_phase = PH_SECOND;
          end else if (hdr_hit && tb_matched) begin
            ack   = 1'b1;
            match = 1'b1;
            rd    = 1'b1;
          end else begin
            tbm_clr = 1'b1;
          end
        end else if (sev_hit) begin
          ack        = 1'b1;
          match      = 1'b1;
          rd         = rx_byte[0];
          next_phase = rx_byte[0] ? PH_IDLE : PH_DATA;
        end else begin
          tbm_clr = 1'b1;
        end
      end
      PH_SECOND: begin
        if (low_hit) begin
          ack        = 1'b1;
          match      = 1'b1;
          tbm_set    = 1'b1;
          next_phase = PH_DATA;
        end else begin
          tbm_clr = 1'b1;
        end
      end
      PH_DATA: begin
        ack        = 1'b1;
        next_phase = PH_DATA;
      end
      default: begin
        next_phase = PH_IDLE;
      end
    endcase
  end
endmodule

// File: rtl/sar_irq_flags.sv
module sar_irq_flags (
  input  logic clk,
  input  logic rst,
  input  logic tcf_evt,
  input  logic match_evt,
  input  logic arb_evt,
  input  logic clr,
  output logic irq_flag,
  output logic arb_flag
);
  logic any_evt;
  assign any_evt = tcf_evt | match_evt | arb_evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_flag <= 1'b0;
      arb_flag <= 1'b0;
    end else begin
      if (any_evt)   irq_flag <= 1'b1;
      else if (clr)  irq_flag <= 1'b0;
      if (arb_evt)   arb_flag <= 1'b1;
      else if (clr)  arb_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_addr_slave.sv
module i2c_addr_slave
  import i2c_sar_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              blk_en,
  input  logic              ten_bit_en,
  input  logic              gc_en,
  input  logic              irq_en,
  input  logic [9:0]        own_addr,
  input  logic              flag_clr,
  input  logic              arb_lost_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [7:0]        rx_data,
  output logic              sel_flag,
  output logic              slave_rd,
  output logic              xfer_done,
  output logic              arb_flag,
  output logic              irq_flag,
  output logic              irq
);
  localparam logic [BCNT_W-1:0] LAST_BIT = BCNT_W'(BYTE_W);
  localparam logic [BCNT_W-1:0] ACK_BIT  = BCNT_W'(ACK_SLOT);

  logic scl_s, sda_s, start_p, stop_p, scl_rise, scl_fall;

  sar_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .start_p(start_p), .stop_p(stop_p),
    .scl_rise(scl_rise), .scl_fall(scl_fall)
  );

  phase_e             phase, pend_phase, dec_next;
  logic [BCNT_W-1:0]  bitcnt;
  logic [BYTE_W-1:0]  sreg;
  logic               tb_matched, pend_match, pend_rd;
  logic               dec_ack, dec_match, dec_rd, dec_tbm_set, dec_tbm_clr;

  sar_addr_decode u_dec (
    .phase(phase), .rx_byte(sreg), .own_addr(own_addr),
    .ten_bit_en(ten_bit_en), .gc_en(gc_en), .tb_matched(tb_matched),
    .ack(dec_ack), .match(dec_match), .rd(dec_rd),
    .tbm_set(dec_tbm_set), .tbm_clr(dec_tbm_clr), .next_phase(dec_next)
  );

  logic active, slot_end, tcf_evt, match_evt, arb_evt;
  assign active    = (phase != PH_IDLE);
  assign slot_end  = active && scl_fall && (bitcnt == ACK_BIT);
  assign tcf_evt   = blk_en && slot_end && sda_oe;
  assign match_evt = blk_en && slot_end && pend_match;
  assign arb_evt   = blk_en && arb_lost_i;

  always_ff @(posedge clk) begin
    if (rst || !blk_en) begin
      phase      <= PH_IDLE;
      pend_phase <= PH_IDLE;
      bitcnt     <= '0;
      sreg       <= '0;
      tb_matched <= 1'b0;
      pend_match <= 1'b0;
      pend_rd    <= 1'b0;
      sda_oe     <= 1'b0;
      rx_data    <= '0;
      sel_flag   <= 1'b0;
      slave_rd   <= 1'b0;
      xfer_done  <= 1'b0;
    end else if (start_p) begin
      phase      <= PH_FIRST;
      bitcnt     <= '0;
      pend_match <= 1'b0;
      sda_oe     <= 1'b0;
      sel_flag   <= 1'b0;
      slave_rd   <= 1'b0;
      xfer_done  <= 1'b0;
    end else if (stop_p) begin
      phase      <= PH_IDLE;
      bitcnt     <= '0;
      tb_matched <= 1'b0;
      pend_match <= 1'b0;
      sda_oe     <= 1'b0;
      sel_flag   <= 1'b0;
      slave_rd   <= 1'b0;
      xfer_done  <= 1'b0;
    end else if (active) begin
      if (scl_rise) begin
        if (bitcnt < LAST_BIT) sreg <= {sreg[BYTE_W-2:0], sda_s};
        if (bitcnt == '0) xfer_done <= 1'b0;
        bitcnt <= bitcnt + 1'b1;
      end else if (scl_fall && bitcnt == LAST_BIT) begin
        sda_oe     <= dec_ack;
        pend_match <= dec_match;
        pend_rd    <= dec_rd;
        pend_phase <= dec_next;
        rx_data    <= sreg;
        if (dec_tbm_set)      tb_matched <= 1'b1;
        else if (dec_tbm_clr) tb_matched <= 1'b0;
      end else if (slot_end) begin
        sda_oe     <= 1'b0;
        bitcnt     <= '0;
        phase      <= pend_phase;
        pend_match <= 1'b0;
        if (sda_oe) xfer_done <= 1'b1;
        if (pend_match) begin
          sel_flag <= 1'b1;
          slave_rd <= pend_rd;
        end
      end
    end
  end

  sar_irq_flags u_flags (
    .clk(clk), .rst(rst), .tcf_evt(tcf_evt), .match_evt(match_evt),
    .arb_evt(arb_evt), .clr(flag_clr), .irq_flag(irq_flag), .arb_flag(arb_flag)
  );

  assign irq = irq_flag & irq_en;
endmodule

// File: rtl/sar_checker.sv
module sar_checker (
  input logic clk,
  input logic rst,
  input logic blk_en,
  input logic irq_en,
  input logic arb_lost_i,
  input logic scl_s,
  input logic start_p,
  input logic stop_p,
  input logic sda_oe,
  input logic sel_flag,
  input logic slave_rd,
  input logic xfer_done,
  input logic arb_flag,
  input logic irq_flag,
  input logic irq
);
  p_ack_scl_low_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_s);

  p_rd_needs_sel_r7: assert property (@(posedge clk) disable iff (rst)
    slave_rd |-> sel_flag);

  p_start_clears_done_r9: assert property (@(posedge clk) disable iff (rst)
    (start_p && blk_en) |=> !xfer_done);

  p_set_beats_clear_r10: assert property (@(posedge clk) disable iff (rst)
    (arb_lost_i && blk_en) |=> (irq_flag && arb_flag));

  p_irq_masked_r11: assert property (@(posedge clk) disable iff (rst)
    !irq_en |-> !irq);

  p_disabled_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    !blk_en |=> (!sda_oe && !sel_flag && !xfer_done));

  p_stop_clears_sel_r13: assert property (@(posedge clk) disable iff (rst)
    (stop_p && blk_en) |=> (!sel_flag && !slave_rd));
endmodule

bind i2c_addr_slave sar_checker u_chk (
  .clk(clk), .rst(rst), .blk_en(blk_en), .irq_en(irq_en),
  .arb_lost_i(arb_lost_i), .scl_s(scl_s), .start_p(start_p), .stop_p(stop_p),
  .sda_oe(sda_oe), .sel_flag(sel_flag), .slave_rd(slave_rd),
  .xfer_done(xfer_done), .arb_flag(arb_flag), .irq_flag(irq_flag), .irq(irq)
);

// File: tb/sim_i2c_addr_slave.sv
module sim_i2c_addr_slave;
  localparam int H = 8;
  localparam int Q = 2;
  localparam logic [9:0] OWN7  = 10'h03A;
  localparam logic [9:0] OWN10 = 10'h2C7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic blk_en = 1'b0, ten_bit_en = 1'b0, gc_en = 1'b0, irq_en = 1'b0;
  logic [9:0] own_addr = OWN7;
  logic flag_clr = 1'b0, arb_lost_i = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic scl_i, sda_i;
  logic sda_oe, sel_flag, slave_rd, xfer_done, arb_flag, irq_flag, irq;
  logic [7:0] rx_data;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  assign scl_i = scl_m;
  assign sda_i = sda_m & ~sda_oe;

  i2c_addr_slave u0 (
    .clk(clk), .rst(rst), .blk_en(blk_en), .ten_bit_en(ten_bit_en),
    .gc_en(gc_en), .irq_en(irq_en), .own_addr(own_addr), .flag_clr(flag_clr),
    .arb_lost_i(arb_lost_i), .scl_i(scl_i), .sda_i(sda_i), .sda_oe(sda_oe),
    .rx_data(rx_data), .sel_flag(sel_flag), .slave_rd(slave_rd),
    .xfer_done(xfer_done), .arb_flag(arb_flag), .irq_flag(irq_flag), .irq(irq)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_clk(H);
    scl_m = 1'b1; wait_clk(H);
    sda_m = 1'b0; wait_clk(H);
    scl_m = 1'b0; wait_clk(H);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_clk(H);
    scl_m = 1'b1; wait_clk(H);
    sda_m = 1'b1; wait_clk(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      wait_clk(Q);
      sda_m = b[i]; wait_clk(H);
      scl_m = 1'b1; wait_clk(H);
      scl_m = 1'b0;
    end
    wait_clk(Q);
    sda_m = 1'b1; wait_clk(H);
    scl_m = 1'b1; wait_clk(H/2);
    acked = ~sda_i;
    wait_clk(H/2);
    scl_m = 1'b0; wait_clk(H);
  endtask

  task automatic pulse_clr();
    flag_clr = 1'b1; wait_clk(1);
    flag_clr = 1'b0; wait_clk(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] b;
    wait_clk(4);
    // R1: reset state
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 outputs", {rx_data, sel_flag, slave_rd, xfer_done, arb_flag, irq_flag, irq}, 0);
    rst = 1'b0;
    wait_clk(2);
    chk("R1 after release", {sel_flag, xfer_done, irq_flag, irq}, 0);

    // R12: disabled block ignores its own address
    bus_start(); send_byte(8'h74, a); bus_stop();
    chk("R12 no ack", a, 0);
    chk("R12 no flags", {sel_flag, xfer_done, irq_flag}, 0);

    blk_en = 1'b1;
    // R4: general call not accepted when disabled
    bus_start(); send_byte(8'h00, a);
    chk("R4 gc off no ack", a, 0);
    chk("R4 gc off sel", sel_flag, 0);
    bus_stop();

    // R2, R9, R13: write to own 7-bit address, then data
    bus_start(); send_byte(8'h74, a);
    chk("R2 ack", a, 1);
    chk("R2 sel/rd", {sel_flag, slave_rd}, 2'b10);
    chk("R2 rx_data", rx_data, 8'h74);
    chk("R10 match sets flag", irq_flag, 1);
    chk("R11 irq masked", irq, 0);
    send_byte(8'h5C, a);
    chk("R9 data ack", a, 1);
    chk("R9 xfer_done", xfer_done, 1);
    chk("R9 rx_data", rx_data, 8'h5C);
    send_byte(8'hA3, a);
    chk("R9 second data", {a, xfer_done, rx_data}, {2'b11, 8'hA3});
    bus_stop();
    chk("R13 stop clears", {sel_flag, slave_rd}, 0);

    // R10/R11: flag handling
    irq_en = 1'b1; wait_clk(1);
    chk("R11 irq on", irq, 1);
    pulse_clr();
    chk("R10 clear", {irq_flag, irq}, 0);
    arb_lost_i = 1'b1; flag_clr = 1'b1; wait_clk(1);
    arb_lost_i = 1'b0; flag_clr = 1'b0; wait_clk(1);
    chk("R10 set wins", {irq_flag, arb_flag}, 2'b11);
    pulse_clr();
    chk("R10 arb clear", {irq_flag, arb_flag}, 0);
    irq_en = 1'b0;

    // R2, R3, R4: sweep of every first byte, general call enabled
    gc_en = 1'b1;
    for (int v = 0; v < 256; v++) begin
      logic exp_ack, exp_rd;
      b = 8'(v);
      exp_ack = (b[7:1] == OWN7[6:0]) || (b == 8'h00);
      exp_rd  = exp_ack && b[0];
      bus_start(); send_byte(b, a);
      chk(exp_ack ? "R2 sweep ack" : "R3 sweep nack", a, exp_ack);
      chk("R3 sweep sel", {sel_flag, slave_rd, xfer_done}, {exp_ack, exp_rd, exp_ack});
      if (b == 8'h00) chk("R4 gc rx_data", rx_data, 8'h00);
      bus_stop();
    end
    gc_en = 1'b0;

    // 10-bit mode
    ten_bit_en = 1'b1; own_addr = OWN10;
    pulse_clr();
    // R5: header sweep
    for (int h = 0; h < 4; h++) begin
      logic exp_ack;
      b = {5'b11110, 2'(h), 1'b0};
      exp_ack = (2'(h) == OWN10[9:8]);
      bus_start(); send_byte(b, a);
      chk("R5 header ack", a, exp_ack);
      chk("R5 done/sel", {xfer_done, sel_flag}, {exp_ack, 1'b0});
      bus_stop();
    end
    bus_start(); send_byte(8'h74, a);
    chk("R5 7-bit byte ignored", a, 0);
    bus_stop();

    // R6, R7: full 10-bit read handshake
    bus_start(); send_byte(8'hF4, a);
    chk("R5 hdr", {a, sel_flag}, 2'b10);
    send_byte(8'hC7, a);
    chk("R6 low byte ack", a, 1);
    chk("R6 sel", sel_flag, 1);
    bus_start(); send_byte(8'hF7, a);
    chk("R7 other header read nack", a, 0);
    bus_start(); send_byte(8'hF4, a); send_byte(8'hC7, a);
    bus_start(); send_byte(8'hF5, a);
    chk("R7 read ack", a, 1);
    chk("R7 sel/rd", {sel_flag, slave_rd}, 2'b11);
    bus_start(); send_byte(8'hF5, a);
    chk("R7 matched kept over Sr", a, 1);
    bus_stop();

    // R8: stop forgets match
    bus_start(); send_byte(8'hF5, a);
    chk("R8 read after stop nack", {a, sel_flag}, 0);
    bus_stop();

    // R6: low byte mismatch
    bus_start(); send_byte(8'hF4, a); send_byte(8'hC6, a);
    chk("R6 mismatch nack", {a, sel_flag}, 0);
    bus_start(); send_byte(8'hF5, a);
    chk("R7 unmatched read nack", {a, slave_rd}, 0);
    bus_stop();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule